// File: doc/BRIEF.md
# Multi-Width Integer ALU with Condition Codes

This block is the arithmetic and logic stage of a small integer datapath. Each cycle in which `valid_i` is high, it takes an opcode, a size select, a destination operand, a source operand and the current condition codes. It then registers a result, a one-cycle write strobe for that result and a new four-bit condition-code word. Operand fetch and addressing happen upstream. The caller writes the registered result back to its register file when the strobe is high, and feeds the registered flags back on `ccr_i`.

Operands are treated as 8, 16 or 32 bits wide according to the size select, and bits above the selected width are ignored. Flags follow four rule sets:

- Add, subtract, negate and compare produce full arithmetic flags.
- Increment and decrement keep the incoming carry, and overflow looks at the destination before the step.
- AND, OR, XOR and move clear overflow and keep the incoming carry.
- Unassigned opcodes change nothing.

Top module: `mwalu`

## Requirements
- R1: While `rst_n` is low at a rising edge, `ccr_o`, `result_o` and `wr_en_o` become zero.
- R2: The flag word has N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Outputs update one rising edge after `valid_i` is sampled high. While `valid_i` is low, `ccr_o` and `result_o` hold and `wr_en_o` is 0.
- R3: Add (opcode 0) gives (dst + src) modulo 2^w. C is the carry out of bit w-1. V is set when both addends share a sign bit (bit w-1) and the result's sign differs from it.
- R4: Subtract (opcode 1) adds dst to the w-bit two's complement of src. C is set when dst < src as unsigned w-bit values. V follows the R3 rule on dst and the complemented source.
- R5: Negate (opcode 2) adds zero to the w-bit two's complement of src. C is set when src is nonzero. V follows the R3 rule on zero and the complemented source.
- R6: Compare (opcode 3) sets all four flags exactly as subtract does. It raises no write strobe and leaves `result_o` unchanged.
- R7: Increment (opcode 4) gives dst + src and decrement (opcode 5) gives dst - src, modulo 2^w. N and Z come from the result. V is set when bits w-2..0 of dst are all ones. C is copied from `ccr_i[0]`.
- R8: AND (6), OR (7) and XOR (8) set N from bit w-1 of the result and Z when the result is zero. They clear V and copy C from `ccr_i[0]`.
- R9: Move (opcode 9) gives the low w bits of src, with the same flag rules as R8.
- R10: Size 0 selects w=8, size 1 selects w=16, and sizes 2 and 3 select w=32. Operand bits above w have no effect on the result or flags, and `result_o` bits above w are zero.
- R11: Opcodes 10 to 15 raise no write strobe and leave `result_o` and `ccr_o` unchanged.
- R12: `wr_en_o` is high for exactly the one cycle after a valid opcode 0-2 or 4-9 is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| size_i | input | 2 | Operand width select |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand or step amount |
| ccr_i | input | 4 | Current condition codes {N,Z,V,C} |
| result_o | output | 32 | Registered result, zero-extended |
| wr_en_o | output | 1 | Result write strobe |
| ccr_o | output | 4 | Registered next condition codes |

## Verification
The bench targets carry and overflow at each width's edge: 0xFF+1, 0x7FFF+1, 0xFFFFFFFF+1, 0x80-1, and a long-form add at size 3. A design that took the sign or carry from the wrong bit position would report the wrong V or C there. Subtract and negate are checked for a borrow-style C: an inverted carry would flip C on 5-1 and 1-5. Increment and decrement are checked at 0x7F and 0x7FFFFFFF, where a design that judged overflow from the result instead of the prior destination, or that touched C, would disagree. Compare and illegal opcodes must leave the result alone. Upper operand bits must not leak into a byte-wide Z flag or into the result.

// File: rtl/mwalu_pkg.sv
// Shared opcode, size and flag-position definitions for the multi-width ALU.
// Assumes a 4-bit opcode field and a 2-bit size field.
package mwalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_NEG = 4'd2,
        OP_CMP = 4'd3,
        OP_INC = 4'd4,
        OP_DEC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_MOV = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } alu_size_e;

    localparam int unsigned CC_N = 3;
    localparam int unsigned CC_Z = 2;
    localparam int unsigned CC_V = 1;
    localparam int unsigned CC_C = 0;

    localparam int unsigned NUM_LANES = 3;

endpackage

// File: rtl/mwalu_sizer.sv
// Width decoder: turns the size select into an operand mask and a one-hot
// sign-bit mask. Assumes BYTE_W < WORD_W <= DATA_W.
module mwalu_sizer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WORD_W = 16
) (
    input  logic [1:0]        size_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] sign_o
);
    import mwalu_pkg::*;

    logic [NUM_LANES-1:0][DATA_W-1:0] lane_mask;
    logic [NUM_LANES-1:0][DATA_W-1:0] lane_sign;
    logic [1:0]                       lane_sel;

    // Build one mask pair per supported width.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int unsigned LW = (g == 0) ? BYTE_W : ((g == 1) ? WORD_W : DATA_W);
        assign lane_mask[g] = {DATA_W{1'b1}} >> (DATA_W - LW);
        assign lane_sign[g] = {{(DATA_W-1){1'b0}}, 1'b1} << (LW - 1);
    end

    // Map the size code onto a lane; both upper codes mean the full width.
    always_comb begin
        case (alu_size_e'(size_i))
            SZ_BYTE: lane_sel = 2'd0;
            SZ_WORD: lane_sel = 2'd1;
            default: lane_sel = 2'd2;
        endcase
    end

    assign mask_o = lane_mask[lane_sel];
    assign sign_o = lane_sign[lane_sel];

endmodule

// File: rtl/mwalu_arith.sv
// Adder path for add, subtract, negate, compare, increment and decrement.
// Produces the masked sum plus the V and C flags. Assumes the operands
// arrive already masked to the selected width.
module mwalu_arith #(
    parameter int unsigned DATA_W = 32
) (
    input  mwalu_pkg::alu_op_e op_i,
    input  logic [DATA_W-1:0]  dst_i,
    input  logic [DATA_W-1:0]  src_i,
    input  logic [DATA_W-1:0]  mask_i,
    input  logic [DATA_W-1:0]  sign_i,
    input  logic               c_in_i,
    output logic [DATA_W-1:0]  res_o,
    output logic               v_o,
    output logic               c_o
);
    import mwalu_pkg::*;

    logic [DATA_W-1:0] neg_src;
    logic [DATA_W-1:0] add_a;
    logic [DATA_W-1:0] add_b;
    logic [DATA_W:0]   sum;
    logic              sgn_a, sgn_b, sgn_r;
    logic              v_add, v_step, carry, borrow;

    // Two's complement of the source within the selected width.
    assign neg_src = (~src_i + {{(DATA_W-1){1'b0}}, 1'b1}) & mask_i;

    // Choose the two addends for the current opcode.
    always_comb begin
        add_a = dst_i;
        add_b = src_i;
        case (op_i)
            OP_SUB, OP_CMP, OP_DEC: add_b = neg_src;
            OP_NEG: begin
                add_a = '0;
                add_b = neg_src;
            end
            default: ;
        endcase
    end

    assign sum    = {1'b0, add_a} + {1'b0, add_b};
    assign res_o  = sum[DATA_W-1:0] & mask_i;
    assign sgn_a  = |(add_a & sign_i);
    assign sgn_b  = |(add_b & sign_i);
    assign sgn_r  = |(res_o & sign_i);
    assign v_add  = (sgn_a == sgn_b) && (sgn_r != sgn_a);
    assign v_step = (dst_i & (mask_i >> 1)) == (mask_i >> 1);
    assign carry  = |(sum[DATA_W:1] & sign_i);
    assign borrow = add_a < src_i;

    // Pick the V and C rules for the opcode family.
    always_comb begin
        case (op_i)
            OP_ADD:                 begin v_o = v_add;  c_o = carry;  end
            OP_SUB, OP_CMP, OP_NEG: begin v_o = v_add;  c_o = borrow; end
            OP_INC, OP_DEC:         begin v_o = v_step; c_o = c_in_i; end
            default:                begin v_o = 1'b0;   c_o = c_in_i; end
        endcase
    end

endmodule

// File: rtl/mwalu_logic.sv
// Bitwise path for AND, OR, XOR and move. Assumes masked operands; the
// output is therefore already confined to the selected width.
module mwalu_logic #(
    parameter int unsigned DATA_W = 32
) (
    input  mwalu_pkg::alu_op_e op_i,
    input  logic [DATA_W-1:0]  dst_i,
    input  logic [DATA_W-1:0]  src_i,
    output logic [DATA_W-1:0]  res_o
);
    import mwalu_pkg::*;

    // Select the bitwise function.
    always_comb begin
        case (op_i)
            OP_AND:  res_o = dst_i & src_i;
            OP_OR:   res_o = dst_i | src_i;
            OP_XOR:  res_o = dst_i ^ src_i;
            default: res_o = src_i;
        endcase
    end

endmodule

// File: rtl/mwalu.sv
// Multi-width ALU top. Masks the operands to the selected width, runs the
// adder and bitwise paths, forms {N,Z,V,C} and registers the result, the
// write strobe and the flags on a valid strobe. Synchronous active-low
// reset. Assumes the caller feeds back the flags on ccr_i.
module mwalu #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned OP_W   = 4,
    parameter int unsigned SZ_W   = 2,
    parameter int unsigned CC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [SZ_W-1:0]   size_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [CC_W-1:0]   ccr_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [CC_W-1:0]   ccr_o
);
    import mwalu_pkg::*;

    alu_op_e           op;
    logic [DATA_W-1:0] mask, sign, dst_m, src_m;
    logic [DATA_W-1:0] ar_res, lg_res, res_sel;
    logic              ar_v, ar_c;
    logic              is_arith, is_legal, writes;
    logic [CC_W-1:0]   cc_next;
    logic [DATA_W-1:0] res_q;
    logic [CC_W-1:0]   cc_q;
    logic              wr_q;

    assign op = alu_op_e'(op_i);

    mwalu_sizer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_sizer (
        .size_i (size_i),
        .mask_o (mask),
        .sign_o (sign)
    );

    assign dst_m = dst_i & mask;
    assign src_m = src_i & mask;

    mwalu_arith #(.DATA_W(DATA_W)) u_arith (
        .op_i   (op),
        .dst_i  (dst_m),
        .src_i  (src_m),
        .mask_i (mask),
        .sign_i (sign),
        .c_in_i (ccr_i[CC_C]),
        .res_o  (ar_res),
        .v_o    (ar_v),
        .c_o    (ar_c)
    );

    mwalu_logic #(.DATA_W(DATA_W)) u_logic (
        .op_i  (op),
        .dst_i (dst_m),
        .src_i (src_m),
        .res_o (lg_res)
    );

    // Classify the opcode into family, legality and write behaviour.
    always_comb begin
        is_arith = op_i <= OP_W'(OP_DEC);
        is_legal = op_i <= OP_W'(OP_MOV);
        writes   = is_legal && (op != OP_CMP);
    end

    // Merge the paths and assemble the packed flag word.
    always_comb begin
        res_sel       = is_arith ? ar_res : lg_res;
        cc_next       = '0;
        cc_next[CC_N] = |(res_sel & sign);
        cc_next[CC_Z] = (res_sel == '0);
        cc_next[CC_V] = is_arith ? ar_v : 1'b0;
        cc_next[CC_C] = is_arith ? ar_c : ccr_i[CC_C];
    end

    // Register result, strobe and flags on a valid legal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            cc_q  <= '0;
            wr_q  <= 1'b0;
        end else begin
            wr_q <= valid_i && writes;
            if (valid_i && is_legal) begin
                cc_q <= cc_next;
                if (writes) begin
                    res_q <= res_sel;
                end
            end
        end
    end

    assign result_o = res_q;
    assign wr_en_o  = wr_q;
    assign ccr_o    = cc_q;

endmodule

// File: rtl/mwalu_chk.sv
// Assertion checker for the multi-width ALU, attached by bind. Observes
// ports only. Assumes the default 32-bit data width for the size-specific
// bit positions.
module mwalu_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [3:0]        op_i,
    input logic [1:0]        size_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] src_i,
    input logic [3:0]        ccr_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [3:0]        ccr_o
);
    logic logic_op, step_op, mov_long;
    assign logic_op = (op_i >= 4'd6) && (op_i <= 4'd9);
    assign step_op  = (op_i == 4'd4) || (op_i == 4'd5);
    assign mov_long = (op_i == 4'd9) && (size_i[1] == 1'b1);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (ccr_o == 4'd0) && !wr_en_o && (result_o == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(ccr_o) && $stable(result_o) && !wr_en_o);

    p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd3) |=> !wr_en_o && $stable(result_o));

    p_step_keep_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && step_op) |=> ccr_o[0] == $past(ccr_i[0]));

    p_logic_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && logic_op) |=> !ccr_o[1] && (ccr_o[0] == $past(ccr_i[0])));

    p_mov_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mov_long) |=> result_o == $past(src_i));

    p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && size_i == 2'd0 && op_i != 4'd3 && op_i <= 4'd9)
        |=> (result_o[DATA_W-1:8] == '0) && (ccr_o[2] == (result_o[7:0] == 8'd0)));

    p_illegal_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i >= 4'd10) |=> !wr_en_o && $stable(ccr_o) && $stable(result_o));

    p_strobe_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(valid_i) && ($past(op_i) <= 4'd9) && ($past(op_i) != 4'd3));

    // Keeps the destination operand referenced for completeness of the port set.
    p_dst_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> !$isunknown(dst_i));

endmodule

bind mwalu mwalu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .dst_i    (dst_i),
    .src_i    (src_i),
    .ccr_i    (ccr_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .ccr_o    (ccr_o)
);

// File: tb/mwalu_tb.sv
// Directed bench for the multi-width ALU. One task per scenario; a
// reference model written from the requirements supplies expected values.
module mwalu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] src_i = '0;
    logic [3:0]  ccr_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  ccr_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_res = '0;
    logic [3:0]  last_cc = '0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    always #10 clk = ~clk;

    mwalu u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .size_i(size_i), .dst_i(dst_i), .src_i(src_i), .ccr_i(ccr_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .ccr_o(ccr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: w-bit arithmetic on 64-bit integers.
    task automatic model(input logic [3:0] op, input logic [1:0] sz,
                         input logic [31:0] d, input logic [31:0] s, input logic cin,
                         output logic [31:0] res, output logic wr, output logic [3:0] cc,
                         output logic legal);
        longint unsigned w, m, a, b, r, sa, sb, sr;
        logic n, z, v, c;
        w = (sz == 2'd0) ? 8 : ((sz == 2'd1) ? 16 : 32);
        m = (64'd1 << w) - 1;
        a = d & m; b = s & m; r = 0; v = 0; c = cin;
        legal = (op <= 4'd9);
        wr = legal && (op != 4'd3);
        case (op)
            4'd0: begin r = a + b; c = ((r >> w) & 1) != 0; end
            4'd1, 4'd3: begin c = a < b; b = (m + 1 - b) & m; r = a + b; end
            4'd2: begin c = b != 0; a = 0; b = (m + 1 - b) & m; r = b; end
            4'd4: r = a + b;
            4'd5: r = a + m + 1 - b;
            4'd6: r = a & b;
            4'd7: r = a | b;
            4'd8: r = a ^ b;
            default: r = b;
        endcase
        r = r & m;
        sa = (a >> (w - 1)) & 1; sb = (b >> (w - 1)) & 1; sr = (r >> (w - 1)) & 1;
        if (op <= 4'd3) v = (sa == sb) && (sr != sa);
        else if (op <= 4'd5) v = ((d & (m >> 1)) == (m >> 1));
        n = sr != 0; z = (r == 0);
        res = r[31:0];
        cc = {n, z, v, c};
    endtask

    task automatic run_op(input string tag, input logic [3:0] op, input logic [1:0] sz,
                          input logic [31:0] d, input logic [31:0] s, input logic [3:0] cin);
        logic [31:0] er; logic ew; logic [3:0] ec; logic lg;
        @(negedge clk);
        op_i = op; size_i = sz; dst_i = d; src_i = s; ccr_i = cin; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        model(op, sz, d, s, cin[0], er, ew, ec, lg);
        if (lg) begin
            if (ew) last_res = er;
            last_cc = ec;
        end
        chk({tag, " result"}, result_o, last_res);
        chk({tag, " wr_en"}, {31'd0, wr_en_o}, {31'd0, ew});
        chk({tag, " ccr"}, {28'd0, ccr_o}, {28'd0, last_cc});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset result", result_o, 32'd0);
        chk("R1 reset ccr", {28'd0, ccr_o}, 32'd0);
        chk("R1 reset wr_en", {31'd0, wr_en_o}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run_op("R3 add byte carry", 4'd0, 2'd0, 32'hFF, 32'h01, 4'd0);
        chk("R3 byte wrap lit", result_o, 32'h0);
        chk("R2 R3 flag order ZC", {28'd0, ccr_o}, 32'h5);
        run_op("R3 add word ovf", 4'd0, 2'd1, 32'h7FFF, 32'h1, 4'd0);
        chk("R3 word ovf lit", {28'd0, ccr_o}, 32'hA);
        run_op("R3 add long carry", 4'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 4'd0);
        chk("R3 long carry lit", {28'd0, ccr_o}, 32'h5);
    endtask

    task automatic t_sub();
        run_op("R4 sub no borrow", 4'd1, 2'd0, 32'h05, 32'h01, 4'd0);
        chk("R4 5-1 lit", {28'd0, ccr_o}, 32'h0);
        run_op("R4 sub borrow", 4'd1, 2'd0, 32'h01, 32'h05, 4'd0);
        chk("R4 1-5 lit", {result_o[7:0], 20'd0, ccr_o}, {8'hFC, 20'd0, 4'h9});
        run_op("R4 sub ovf", 4'd1, 2'd0, 32'h80, 32'h01, 4'd0);
        chk("R4 80-1 lit", {28'd0, ccr_o}, 32'h2);
    endtask

    task automatic t_neg();
        run_op("R5 neg one", 4'd2, 2'd0, 32'h55, 32'h01, 4'd0);
        chk("R5 neg one lit", {result_o[7:0], 20'd0, ccr_o}, {8'hFF, 20'd0, 4'h9});
        run_op("R5 neg zero", 4'd2, 2'd0, 32'h55, 32'h00, 4'd1);
        chk("R5 neg zero lit", {28'd0, ccr_o}, 32'h4);
        run_op("R5 neg min word", 4'd2, 2'd1, 32'h0, 32'h8000, 4'd0);
    endtask

    task automatic t_cmp();
        run_op("R6 seed", 4'd9, 2'd2, 32'h0, 32'hCAFE_0001, 4'd0);
        run_op("R6 cmp equal", 4'd3, 2'd1, 32'h1234, 32'h1234, 4'd0);
        chk("R6 cmp keeps result", result_o, 32'hCAFE_0001);
        chk("R6 cmp flags", {28'd0, ccr_o}, 32'h4);
        run_op("R6 cmp less", 4'd3, 2'd2, 32'h1, 32'h2, 4'd0);
    endtask

    task automatic t_step();
        run_op("R7 inc 7F", 4'd4, 2'd0, 32'h7F, 32'h1, 4'd1);
        chk("R7 inc 7F lit", {28'd0, ccr_o}, 32'hB);
        run_op("R7 dec 00", 4'd5, 2'd0, 32'h00, 32'h1, 4'd0);
        chk("R7 dec wrap lit", {result_o[7:0], 20'd0, ccr_o}, {8'hFF, 20'd0, 4'h8});
        run_op("R7 dec long 7FFFFFFF", 4'd5, 2'd2, 32'h7FFF_FFFF, 32'h2, 4'd0);
        chk("R7 dec long lit", {28'd0, ccr_o}, 32'h2);
        run_op("R7 inc word keep C", 4'd4, 2'd1, 32'hFFFF, 32'h1, 4'd1);
    endtask

    task automatic t_logic();
        run_op("R8 and zero", 4'd6, 2'd0, 32'hF0, 32'h0F, 4'hF);
        chk("R8 and lit", {28'd0, ccr_o}, 32'h5);
        run_op("R8 or word", 4'd7, 2'd1, 32'h8000, 32'h0001, 4'd0);
        run_op("R8 xor long", 4'd8, 2'd2, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 4'd1);
        run_op("R9 mov byte", 4'd9, 2'd0, 32'hFFFF_FFFF, 32'h1234_5680, 4'd0);
        chk("R9 mov lit", {result_o, 28'd0, ccr_o}, {32'h80, 28'd0, 4'h8});
    endtask

    task automatic t_width();
        run_op("R10 upper ignored", 4'd0, 2'd0, 32'hABCD_EF00, 32'h1200_0000, 4'd0);
        chk("R10 Z low only", {28'd0, ccr_o}, 32'h4);
        run_op("R10 size3 long", 4'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 4'd0);
        chk("R10 size3 lit", {28'd0, ccr_o}, 32'h7);
    endtask

    task automatic t_illegal_idle();
        run_op("R11 seed", 4'd0, 2'd1, 32'h0100, 32'h0023, 4'd0);
        run_op("R11 op C", 4'd12, 2'd2, 32'hFFFF_FFFF, 32'h1, 4'hF);
        run_op("R11 op F", 4'd15, 2'd0, 32'h0, 32'h0, 4'd0);
        chk("R11 result held", result_o, 32'h0123);
        @(negedge clk);
        op_i = 4'd0; dst_i = 32'hFFFF_FFFF; src_i = 32'h1; ccr_i = 4'hF;
        repeat (2) @(negedge clk);
        chk("R2 idle result", result_o, 32'h0123);
        chk("R2 idle ccr", {28'd0, ccr_o}, {28'd0, last_cc});
        chk("R12 idle strobe low", {31'd0, wr_en_o}, 32'd0);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 360; i++) begin
            logic [31:0] d, s;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            d = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            s = (i % 4 == 0) ? {30'd0, lfsr[1:0]} : lfsr;
            if (i % 7 == 0) d = d | 32'h7FFF_FF7F;
            run_op("R3 R12 sweep", 4'(i % 11), 2'((i / 11) % 4), d, s, lfsr[7:4]);
        end
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_neg();
        t_cmp();
        t_step();
        t_logic();
        t_width();
        t_illegal_idle();
        t_sweep();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule